// File: doc/BRIEF.md
# Lamp Fault Status Monitor

This block watches a fluorescent backlight lamp for two kinds of fault and reports each as a status bit. The first fault is a missing lamp. If the lamp current does not rise above its detection threshold for one full second while the lamp is meant to be lit, the block latches a lamp-out fault. That fault turns the lamp off until a shutdown/restart request re-arms it. The second fault is overcurrent. Its status bit follows the digital PWM dimming periods: it drops as soon as an overcurrent is flagged and is restored at the start of a period that begins cleanly.

The one-second window is counted in ticks of an external timebase. A parameter sets the number of ticks, so a bench can use a short window. The count restarts each time lamp current is detected, and it stays at zero while the lamp is off, in shutdown, or already faulted.

Top module: `lamp_fault_monitor`

## Requirements
- R1: Out of reset, `lamp_ok_o` = 1 and `no_ovc_o` = 1.
- R2: While running, `lamp_ok_o` falls to 0 on the clock edge that samples the TICKS-th `tick_i` with `lamp_det_i` = 0 on every cycle since the count last restarted. Running means `lamp_on_i` = 1, `shdn_i` = 0 and `lamp_ok_o` = 1.
- R3: A cycle with `lamp_det_i` = 1 restarts the tick count, so a fault needs TICKS further ticks after it.
- R4: Once `lamp_ok_o` is 0, it stays 0 until `shdn_i` is asserted, whatever `lamp_det_i` does.
- R5: `lamp_en_o` is 1 exactly when `lamp_on_i` = 1, `shdn_i` = 0 and `lamp_ok_o` = 1, with no added cycle.
- R6: A cycle with `shdn_i` = 1 sets `lamp_ok_o` to 1 on the next edge and restarts the tick count.
- R7: Ticks seen while `lamp_on_i` = 0 or `shdn_i` = 1 do not count, and the count restarts from zero.
- R8: A cycle with `ovc_i` = 1 makes `no_ovc_o` 0 on the next edge, even if `period_start_i` is also 1.
- R9: A cycle with `period_start_i` = 1 and `ovc_i` = 0 makes `no_ovc_o` 1 on the next edge.
- R10: In a cycle with neither `ovc_i` nor `period_start_i`, `no_ovc_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick strobe for the lamp-out window |
| lamp_det_i | input | 1 | Lamp current is above the detection threshold |
| lamp_on_i | input | 1 | Dimming logic wants the lamp lit |
| shdn_i | input | 1 | Shutdown/restart request; re-arms the lamp-out fault |
| ovc_i | input | 1 | Overcurrent seen in the current PWM period |
| period_start_i | input | 1 | Start-of-period strobe of the PWM dimming |
| lamp_ok_o | output | 1 | Lamp present status (0 = lamp-out latched) |
| no_ovc_o | output | 1 | No-overcurrent status (0 = overcurrent this period) |
| lamp_en_o | output | 1 | Gated lamp enable to the converter |

## Verification
The hardest case to reach is a fault at the exact window boundary. It needs TICKS ticks with no detection between them, and no shutdown or lamp-off in the same span. The directed part drives exactly TICKS-1 ticks, checks that the status still holds, then sends one more tick. It also places a single detection just before the last tick to show that the count restarts. Random stimulus uses a short window and a low detection rate, so expiries, re-arms and clashes between overcurrent and period starts happen often. A bench model tracks all of them.

// File: rtl/lamp_fault_pkg.sv
package lamp_fault_pkg;
  typedef struct packed {
    logic lamp_ok;
    logic no_ovc;
  } fault_status_t;

  localparam fault_status_t STATUS_RESET = '{lamp_ok: 1'b1, no_ovc: 1'b1};
endpackage

// File: rtl/lamp_out_timer.sv
module lamp_out_timer #(
  parameter int unsigned TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + CW'(1);
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // count restarts when the timer is not running
  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/lamp_out_latch.sv
module lamp_out_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic rearm_i,
  output logic ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ok_o <= 1'b1;
    else if (rearm_i)  ok_o <= 1'b1;
    else if (expire_i) ok_o <= 1'b0;
  end

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_o && !rearm_i) |=> !ok_o);
  p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> ok_o);
  p_fall_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !expire_i) |=> ok_o);
endmodule

// File: rtl/ovc_period_flag.sv
module ovc_period_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovc_i,
  input  logic period_start_i,
  output logic no_ovc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             no_ovc_o <= 1'b1;
    else if (ovc_i)          no_ovc_o <= 1'b0;
    else if (period_start_i) no_ovc_o <= 1'b1;
  end

  p_ovc_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovc_i |=> !no_ovc_o);
  p_period_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && !ovc_i) |=> no_ovc_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_start_i && !ovc_i) |=> $stable(no_ovc_o));
endmodule

// File: rtl/lamp_fault_monitor.sv
module lamp_fault_monitor
  import lamp_fault_pkg::*;
#(
  parameter int unsigned TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lamp_det_i,
  input  logic lamp_on_i,
  input  logic shdn_i,
  input  logic ovc_i,
  input  logic period_start_i,
  output logic lamp_ok_o,
  output logic no_ovc_o,
  output logic lamp_en_o
);
  fault_status_t status;
  logic          run;
  logic          expire;

  // timer only advances while lit, armed and no current seen
  assign run = lamp_on_i && !shdn_i && status.lamp_ok && !lamp_det_i;

  lamp_out_timer #(.TICKS(TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  lamp_out_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .rearm_i  (shdn_i),
    .ok_o     (status.lamp_ok)
  );

  ovc_period_flag u_ovc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ovc_i          (ovc_i),
    .period_start_i (period_start_i),
    .no_ovc_o       (status.no_ovc)
  );

  assign lamp_ok_o = status.lamp_ok;
  assign no_ovc_o  = status.no_ovc;
  assign lamp_en_o = lamp_on_i && !shdn_i && status.lamp_ok;

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_ok_o |-> !lamp_en_o);
  p_det_no_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_ok_o && lamp_det_i) |=> lamp_ok_o);
endmodule

// File: tb/lamp_fault_monitor_bench.sv
module lamp_fault_monitor_bench;
  localparam int unsigned L = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, lamp_det_i = 0, lamp_on_i = 0, shdn_i = 0, ovc_i = 0, period_start_i = 0;
  logic lamp_ok_o, no_ovc_o, lamp_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit m_ok = 1, m_nov = 1;
  int m_cnt = 0;

  lamp_fault_monitor #(.TICKS(L)) u_lamp_fault_monitor (
    .clk_i, .rst_ni, .tick_i, .lamp_det_i, .lamp_on_i, .shdn_i,
    .ovc_i, .period_start_i, .lamp_ok_o, .no_ovc_o, .lamp_en_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit run;
    run = lamp_on_i && !shdn_i && m_ok && !lamp_det_i;
    if (shdn_i) begin m_ok = 1; m_cnt = 0; end
    else if (!run) m_cnt = 0;
    else if (tick_i) begin
      if (m_cnt == L - 1) begin m_ok = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (ovc_i) m_nov = 0;
    else if (period_start_i) m_nov = 1;
  endtask

  task automatic check_all();
    chk("R2/R4 lamp_ok", lamp_ok_o, m_ok);
    chk("R8/R9/R10 no_ovc", no_ovc_o, m_nov);
    chk("R5 lamp_en", lamp_en_o, lamp_on_i && !shdn_i && m_ok);
  endtask

  task automatic cycle();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  task automatic idle_inputs();
    tick_i = 0; lamp_det_i = 0; lamp_on_i = 1; shdn_i = 0; ovc_i = 0; period_start_i = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    chk("R1 reset lamp_ok", lamp_ok_o, 1'b1);
    chk("R1 reset no_ovc", no_ovc_o, 1'b1);
    rst_ni = 1'b1;
    idle_inputs();

    // R2: exactly L ticks
    tick_i = 1;
    for (int i = 0; i < L - 1; i++) cycle();
    chk("R2 before last tick", lamp_ok_o, 1'b1);
    cycle();
    chk("R2 after L ticks", lamp_ok_o, 1'b0);
    chk("R5 gate off", lamp_en_o, 1'b0);

    // R4: detection does not clear the fault
    tick_i = 0; lamp_det_i = 1;
    repeat (4) cycle();
    chk("R4 sticky", lamp_ok_o, 1'b0);

    // R6: rearm
    lamp_det_i = 0; shdn_i = 1;
    chk("R5 shdn gate", lamp_en_o, 1'b0);
    cycle();
    shdn_i = 0;
    #1 chk("R6 rearmed", lamp_ok_o, 1'b1);
    chk("R5 gate on", lamp_en_o, 1'b1);

    // R3: detection restarts count
    tick_i = 1;
    for (int i = 0; i < L - 1; i++) cycle();
    lamp_det_i = 1; cycle(); lamp_det_i = 0;
    for (int i = 0; i < L - 1; i++) cycle();
    chk("R3 restarted", lamp_ok_o, 1'b1);
    cycle();
    chk("R3 expire after restart", lamp_ok_o, 1'b0);
    shdn_i = 1; cycle(); shdn_i = 0;

    // R7: ticks while lamp off do not count
    lamp_on_i = 0;
    repeat (3 * L) cycle();
    lamp_on_i = 1;
    for (int i = 0; i < L - 1; i++) cycle();
    chk("R7 off ticks ignored", lamp_ok_o, 1'b1);
    tick_i = 0;

    // R8/R9/R10
    ovc_i = 1; period_start_i = 1; cycle();
    chk("R8 ovc wins", no_ovc_o, 1'b0);
    ovc_i = 0; period_start_i = 0; repeat (3) cycle();
    chk("R10 hold", no_ovc_o, 1'b0);
    period_start_i = 1; cycle(); period_start_i = 0;
    chk("R9 restore", no_ovc_o, 1'b1);

    // random phase
    shdn_i = 1; cycle();
    for (int n = 0; n < 4000; n++) begin
      tick_i         = ($urandom % 2) == 0;
      lamp_det_i     = ($urandom % 20) == 0;
      lamp_on_i      = ($urandom % 10) != 0;
      shdn_i         = ($urandom % 100) == 0;
      ovc_i          = ($urandom % 10) == 0;
      period_start_i = ($urandom % 8) == 0;
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule